// File: doc/BRIEF.md
# Row-Buffered DRAM Array Model

This block is a synthesizable behavioural model of a small dynamic memory with a shared address bus. Its storage is a grid of byte-wide cells, four rows by four columns by default. A client reaches any cell in two steps over the same two address pins. First it sends the row index with the row strobe, which copies that whole row into an internal line buffer. Then it sends the column index with the column strobe, which reads or writes one byte in that buffer.

The row strobe is a level. While it is high with the column strobe low, the address names the row to open. While both strobes are high and a row is already open, the address names a column. When the row strobe drops, the open row is closed and the buffer is written back into the array. Opening a different row also writes back the old row first. This lets a client make any number of column accesses against one opened row and then commit them all at once.

Top module: `dram_grid`

## Requirements
- R1: After reset every cell holds zero, no row is open, `rd_vld` is low and `rd_data` is zero.
- R2: A cycle with `ras`=1 and `cas`=0 takes `addr` as the row index and loads that row of the array into the line buffer at that clock edge. The row counts as open from the next cycle on.
- R3: A cycle with `ras`=1, `cas`=1, `we`=0 while a row is open takes `addr` as the column index. The buffered byte at that column appears on `rd_data`, with `rd_vld` high, in the cycle after that edge.
- R4: A column strobe that arrives with no row open has no effect on the buffer or the array, and it raises no `rd_vld`. No row is open while `ras`=0, and none is open in the cycle where the row is first opened.
- R5: Any number of column accesses may follow one row opening. They are served from the buffer, and a read returns the value last written to that column since the row was opened.
- R6: A cycle with `ras`=1, `cas`=1, `we`=1 while a row is open stores `wdata` into the buffered byte at column `addr`, and `rd_vld` stays low in the next cycle.
- R7: A cycle with `ras`=0 while a row is open writes the whole buffer back to that row of the array and closes the row.
- R8: A row command that names a different row while a row is open first writes back the old row and then loads the new one in the same cycle. A row command that names the row already open leaves the buffer untouched.
- R9: `rd_vld` is high in exactly the cycles that follow a column read and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Shared row/column index |
| ras | input | 1 | Row strobe, level |
| cas | input | 1 | Column strobe, level |
| we | input | 1 | Column access writes when high |
| wdata | input | 8 | Byte to store on a column write |
| rd_data | output | 8 | Byte returned by a column read |
| rd_vld | output | 1 | Marks `rd_data` as carrying a read result |

## Verification
The bench targets the orderings in which buffer and array can disagree. It writes a byte and then closes the row, switches to another row, or reopens the same row. A design that skipped the write-back would return stale zeros. A design that reloaded on a same-row reopen would silently drop the pending writes. Column strobes sent while the row strobe is low, or in the very cycle a row opens, must change nothing and must raise no valid pulse. A design that decoded them anyway would corrupt a byte that is read back later. A long pseudo-random strobe stream then compares every cycle against a behavioural model, which exposes a valid flag that lasts too long or shows up after a write.

// File: rtl/dram_grid_pkg.sv
package dram_grid_pkg;
   // decoded meaning of the strobe pair in one cycle
   typedef enum logic [1:0] {
      STB_IDLE  = 2'd0,
      STB_ROW   = 2'd1,
      STB_COL   = 2'd2,
      STB_CLOSE = 2'd3
   } strobe_cmd_e;
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int WORD_W = 8,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int LINE_W = COLS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_en,
   input  logic [ROW_W-1:0]  wb_row,
   input  logic [LINE_W-1:0] wb_line,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [LINE_W-1:0] rd_line
);
   logic [LINE_W-1:0] cells_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n)
            cells_q[r] <= '0;
         else if (wb_en && wb_row == ROW_W'(r))
            cells_q[r] <= wb_line;
      end

      // R7/R8: a stored row changes only through a write-back aimed at it
      a_r7_row_only_on_writeback: assert property (@(posedge clk) disable iff (!rst_n)
         !(wb_en && wb_row == ROW_W'(r)) |=> $stable(cells_q[r]));
   end

   assign rd_line = cells_q[rd_row];
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl
   import dram_grid_pkg::*;
#(
   parameter int ROWS = 4,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras,
   input  logic             cas,
   input  logic [ROW_W-1:0] row_sel,
   output logic             open_q,
   output logic [ROW_W-1:0] open_row_q,
   output logic             load_en,
   output logic             wb_en,
   output logic             col_en
);
   strobe_cmd_e cmd;
   logic        other_row;

   always_comb begin
      if (!ras)
         cmd = STB_CLOSE;
      else if (!cas)
         cmd = STB_ROW;
      else if (open_q)
         cmd = STB_COL;
      else
         cmd = STB_IDLE;
   end

   assign other_row = !open_q || (row_sel != open_row_q);
   assign load_en   = (cmd == STB_ROW) && other_row;
   assign wb_en     = open_q && ((cmd == STB_CLOSE) || ((cmd == STB_ROW) && other_row));
   assign col_en    = (cmd == STB_COL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         open_row_q <= '0;
      end else if (cmd == STB_CLOSE) begin
         open_q     <= 1'b0;
      end else if (load_en) begin
         open_q     <= 1'b1;
         open_row_q <= row_sel;
      end
   end

   // R7: dropping the row strobe leaves no row open
   a_r7_close_on_ras_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ras |=> !open_q);
   // R2: a row command leaves that row open next cycle
   a_r2_row_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (ras && !cas) |=> (open_q && open_row_q == $past(row_sel)));
endmodule

// File: rtl/dram_line_buffer.sv
module dram_line_buffer #(
   parameter int COLS   = 4,
   parameter int WORD_W = 8,
   localparam int COL_W  = $clog2(COLS),
   localparam int LINE_W = COLS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [LINE_W-1:0] load_line,
   input  logic              col_en,
   input  logic              we,
   input  logic [COL_W-1:0]  col_sel,
   input  logic [WORD_W-1:0] wdata,
   output logic [LINE_W-1:0] line_out,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_vld
);
   logic [WORD_W-1:0] slot_q [COLS];

   for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[c] <= '0;
         else if (load_en)
            slot_q[c] <= load_line[c*WORD_W +: WORD_W];
         else if (col_en && we && col_sel == COL_W'(c))
            slot_q[c] <= wdata;
      end
      assign line_out[c*WORD_W +: WORD_W] = slot_q[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= col_en && !we;
         if (col_en && !we)
            rd_data <= slot_q[col_sel];
      end
   end

   // R6: a column write never produces a valid pulse
   a_r6_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (col_en && we) |=> !rd_vld);
   // R5: load and column access never collide in one cycle
   a_r5_load_excludes_col: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en && col_en));
endmodule

// File: rtl/dram_grid.sv
module dram_grid #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int WORD_W = 8,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
   localparam int LINE_W = COLS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ras,
   input  logic              cas,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_vld
);
   if (ROWS < 2 || (1 << ROW_W) != ROWS) begin : g_bad_rows
      $error("dram_grid: ROWS must be a power of two of at least 2");
   end
   if (COLS < 2 || (1 << COL_W) != COLS) begin : g_bad_cols
      $error("dram_grid: COLS must be a power of two of at least 2");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("dram_grid: WORD_W must be positive");
   end

   logic              open_q;
   logic [ROW_W-1:0]  open_row_q;
   logic              load_en, wb_en, col_en;
   logic [LINE_W-1:0] arr_line, buf_line;

   dram_strobe_ctl #(.ROWS(ROWS)) ctl_i (
      .clk, .rst_n, .ras, .cas,
      .row_sel   (addr[ROW_W-1:0]),
      .open_q    (open_q),
      .open_row_q(open_row_q),
      .load_en   (load_en),
      .wb_en     (wb_en),
      .col_en    (col_en)
   );

   dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) arr_i (
      .clk, .rst_n,
      .wb_en  (wb_en),
      .wb_row (open_row_q),
      .wb_line(buf_line),
      .rd_row (addr[ROW_W-1:0]),
      .rd_line(arr_line)
   );

   dram_line_buffer #(.COLS(COLS), .WORD_W(WORD_W)) line_i (
      .clk, .rst_n,
      .load_en  (load_en),
      .load_line(arr_line),
      .col_en   (col_en),
      .we       (we),
      .col_sel  (addr[COL_W-1:0]),
      .wdata    (wdata),
      .line_out (buf_line),
      .rd_data  (rd_data),
      .rd_vld   (rd_vld)
   );

   // R4: a column strobe with no open row raises no valid
   a_r4_closed_cas_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cas && !open_q) |=> !rd_vld);
   // R9: valid only follows a read strobe pair
   a_r9_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> $past(ras && cas && !we && open_q));
   // R3: a read on an open row always produces valid
   a_r3_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (ras && cas && !we && open_q) |=> rd_vld);
endmodule

// File: tb/dram_grid_tb.sv
module dram_grid_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       ras = 1'b0, cas = 1'b0, we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rd_data;
   logic       rd_vld;

   int total = 0, bad = 0;
   bit done = 0;

   // behavioural reference
   byte unsigned m_mem[16];
   byte unsigned m_buf[4];
   bit           m_open = 0;
   int           m_row = 0;
   bit           e_vld = 0;
   byte unsigned e_dat = 0;

   always #5 clk = ~clk;

   dram_grid dut_i (.clk, .rst_n, .addr, .ras, .cas, .we, .wdata, .rd_data, .rd_vld);

   task automatic check(string tag, string what, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
      end
   endtask

   task automatic model_edge(bit r, bit c, bit w, int a, byte unsigned d);
      e_vld = 0;
      if (!r) begin
         if (m_open) for (int k = 0; k < 4; k++) m_mem[m_row*4+k] = m_buf[k];
         m_open = 0;
      end else if (!c) begin
         if (!m_open || a != m_row) begin
            if (m_open) for (int k = 0; k < 4; k++) m_mem[m_row*4+k] = m_buf[k];
            for (int k = 0; k < 4; k++) m_buf[k] = m_mem[a*4+k];
            m_row = a;
            m_open = 1;
         end
      end else if (m_open) begin
         if (w) m_buf[a] = d;
         else begin
            e_dat = m_buf[a];
            e_vld = 1;
         end
      end
   endtask

   // drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(string tag, bit r, bit c, bit w, int a, byte unsigned d);
      ras = r; cas = c; we = w; addr = 2'(a); wdata = d;
      @(posedge clk);
      model_edge(r, c, w, a, d);
      @(negedge clk);
      check(tag, "rd_vld", int'(rd_vld), int'(e_vld));
      if (e_vld) check(tag, "rd_data", int'(rd_data), int'(e_dat));
   endtask

   task automatic read_byte(string tag, int row, int col, byte unsigned exp);
      step(tag, 1, 0, 0, row, 0);
      step(tag, 1, 1, 0, col, 0);
      check(tag, "direct read", int'(rd_data), int'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = 0;
      for (int i = 0; i < 4; i++) m_buf[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "rd_vld at reset", int'(rd_vld), 0);
      check("R1", "rd_data at reset", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R2/R3: every cell reads zero
      for (int r = 0; r < 4; r++) begin
         step("R2", 1, 0, 0, r, 0);
         for (int c = 0; c < 4; c++) step("R1", 1, 1, 0, c, 0);
         step("R7", 0, 0, 0, 0, 0);
      end
      // R6/R5: writes and reads within one opened row
      step("R2", 1, 0, 0, 2, 0);
      step("R6", 1, 1, 1, 1, 8'hA5);
      step("R6", 1, 1, 1, 3, 8'h5A);
      step("R5", 1, 1, 0, 1, 0);
      step("R5", 1, 1, 0, 3, 0);
      step("R5", 1, 1, 1, 1, 8'hC3);
      step("R5", 1, 1, 0, 1, 0);
      check("R5", "overwritten byte", int'(rd_data), 8'hC3);
      // R7: closing commits the buffer
      step("R7", 0, 0, 0, 0, 0);
      read_byte("R7", 2, 1, 8'hC3);
      step("R7", 0, 0, 0, 0, 0);
      // R4: column write with row strobe low is ignored
      step("R4", 0, 1, 1, 1, 8'hFF);
      step("R4", 0, 1, 0, 1, 0);
      read_byte("R4", 2, 1, 8'hC3);
      step("R7", 0, 0, 0, 0, 0);
      // R4: column strobe in the cycle the row first opens is ignored
      step("R4", 1, 1, 1, 0, 8'hEE);
      step("R4", 1, 1, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 0);
      read_byte("R4", 0, 0, 8'h00);
      // R8: switching rows writes back the old one
      step("R6", 1, 1, 1, 3, 8'h3C);
      step("R8", 1, 0, 0, 1, 0);
      step("R8", 1, 1, 0, 3, 0);
      check("R8", "new row col3", int'(rd_data), 8'h00);
      step("R8", 1, 0, 0, 0, 0);
      step("R8", 1, 1, 0, 3, 0);
      check("R8", "written-back byte", int'(rd_data), 8'h3C);
      // R8: reopening the same row keeps pending writes
      step("R8", 1, 0, 0, 3, 0);
      step("R6", 1, 1, 1, 0, 8'h77);
      step("R8", 1, 0, 0, 3, 0);
      step("R8", 1, 1, 0, 0, 0);
      check("R8", "same-row reopen", int'(rd_data), 8'h77);
      // R9: back-to-back reads, then idle
      for (int c = 0; c < 4; c++) step("R9", 1, 1, 0, c, 0);
      step("R9", 1, 0, 0, 3, 0);
      step("R9", 0, 0, 0, 0, 0);
      // R9/R5: pseudo-random strobe stream
      begin
         logic [15:0] lf = 16'hACE1;
         for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R9", lf[0] | lf[7], lf[1], lf[2] & lf[9], int'(lf[4:3]), lf[15:8]);
         end
      end
      step("R7", 0, 0, 0, 0, 0);
      for (int i = 0; i < 16; i++) read_byte("R7", i / 4, i % 4, m_mem[i]);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule